// File: doc/BRIEF.md
# Serial EEPROM Access Guard

This block sits between the host register path and a serial EEPROM controller. It decides, word by word, whether a host access may reach the memory. When reset is released it waits for the auto-load sequencer to hand over configuration word 0. From that word it works out whether protection is switched on and how large the hidden region at the top of the address space is. The outcome then stays fixed until the next reset.

Every host access is a single-cycle request pulse. It ends with a single-cycle acknowledge pulse. A legal access is passed to the EEPROM side as a held request, and any read data is returned when the memory acknowledges. An illegal access never reaches the memory, but the host still receives its acknowledge. A suppressed read returns an all-ones word. A host burst is a run of continuation beats, and each beat takes the next word address. The check is applied to each beat separately. Once one beat of a write burst has been dropped, the rest of that burst is dropped too.

A sticky flag records that at least one access was suppressed. The host clears it with a one-cycle clear pulse.

Top module: `eep_guard`

## Requirements
- R1: While reset is held and right after it is released, `host_ack`, `mem_req` and `blocked_flag` are 0. Protection is off until word 0 has been loaded.
- R2: Protection turns on only if the loaded word 0 has bits [7:6] equal to 2'b01 and bit 4 set. With any other value, every access is forwarded.
- R3: Before word 0 has been loaded, every host read and write is forwarded to the EEPROM side.
- R4: With protection on, a write to word addresses 0x000 through 0x00F is suppressed. A read of those words is forwarded.
- R5: With protection on, bits [3:0] of word 0 give N. The top N×64 words of the 1024-word space are hidden: a read there returns 16'hFFFF, a write there is suppressed, and neither starts an EEPROM access. N = 0 hides nothing.
- R6: A forwarded access raises `mem_req` on the cycle after the host request, with the beat's address, direction and write data. `mem_req` is held unchanged until `mem_ack`. `host_ack` pulses on the cycle after `mem_ack`, and for reads `host_rdata` then holds `mem_rdata`.
- R7: A suppressed access never raises `mem_req`. `host_ack` pulses for exactly one cycle, on the cycle after the request.
- R8: A request with `host_cont` = 1 uses the previous beat's address plus one (wrapping) and ignores `host_addr`. Each beat is checked on its own.
- R9: After a write beat is suppressed, every following continuation write beat is suppressed until a request with `host_cont` = 0 arrives.
- R10: `blocked_flag` goes to 1 on the cycle after any suppressed access. It stays at 1 until a `blocked_clr` pulse clears it.
- R11: Only the first word-0 load after reset is used. Later `load_valid` pulses have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Word 0 delivered by the auto-load sequencer |
| load_word | input | 16 | Contents of word 0 |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_cont | input | 1 | Continuation beat of a burst |
| host_addr | input | 10 | Word address of a starting beat |
| host_wdata | input | 16 | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_ack on reads |
| blocked_clr | input | 1 | Clears blocked_flag |
| blocked_flag | output | 1 | Sticky: an access was suppressed |
| mem_req | output | 1 | EEPROM request, held until mem_ack |
| mem_we | output | 1 | EEPROM access direction |
| mem_addr | output | 10 | EEPROM word address |
| mem_wdata | output | 16 | EEPROM write data |
| mem_ack | input | 1 | EEPROM completion pulse |
| mem_rdata | input | 16 | EEPROM read data, valid with mem_ack |

## Verification
The assertions assume that the host sends a new request only while the guard is idle and not acknowledging. They also assume that the EEPROM side pulses `mem_ack` for one cycle and only while `mem_req` is high. The bench keeps to both rules: its driver issues one request and waits for that request's acknowledge before the next. Its memory model answers each held request exactly once, two cycles after the request appears. Word-0 loads are issued only while no access is in flight, so the protection setting never changes under an outstanding request.

// File: rtl/eep_guard_pkg.sv
// Shared definitions for the EEPROM access guard.
// Assumes a 16-bit configuration word with a fixed field layout.
package eep_guard_pkg;
    localparam int CFG_SIZE_W = 4;   // width of the top-region size field
    localparam int SIG_HI     = 7;   // signature field upper bit
    localparam int SIG_LO     = 6;   // signature field lower bit
    localparam int ENABLE_BIT = 4;   // protection enable bit
    localparam int SIZE_LSB   = 0;   // size field position
    localparam logic [1:0] SIG_GOOD = 2'b01;

    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic                  armed;
        logic [CFG_SIZE_W-1:0] top_blocks;
    } prot_cfg_t;
endpackage

// File: rtl/eep_guard_arm.sv
// Captures word 0 once per reset and derives the protection configuration.
// Assumes load_valid is a pulse; only the first one after reset counts.
module eep_guard_arm
    import eep_guard_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_word,
    output prot_cfg_t         cfg,
    output logic              loaded
);
    logic sig_ok;
    logic en_ok;

    // Decode signature and enable bits of the offered word.
    always_comb begin
        sig_ok = (load_word[SIG_HI:SIG_LO] == SIG_GOOD);
        en_ok  = load_word[ENABLE_BIT];
    end

    // Latch configuration on the first load after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded <= 1'b0;
            cfg    <= '0;
        end else if (load_valid && !loaded) begin
            loaded         <= 1'b1;
            cfg.armed      <= sig_ok && en_ok;
            cfg.top_blocks <= load_word[SIZE_LSB +: CFG_SIZE_W];
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> $stable(cfg)); // R11
    AST_DISARMED_UNTIL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> !cfg.armed); // R3
endmodule

// File: rtl/eep_guard_check.sv
// Classifies one word address against the active protection configuration.
// Purely combinational; assumes top region span never exceeds the space.
module eep_guard_check
    import eep_guard_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int BLK_LOG2    = 6,
    parameter int FIXED_WORDS = 16
) (
    input  prot_cfg_t         cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_block,
    output logic              rd_block
);
    localparam int SPAN_W    = CFG_SIZE_W + BLK_LOG2;
    localparam int SUM_W     = ((ADDR_W > SPAN_W) ? ADDR_W : SPAN_W) + 1;
    localparam int FIX_LOG2  = $clog2(FIXED_WORDS);
    localparam bit FIX_POW2  = ((FIXED_WORDS & (FIXED_WORDS - 1)) == 0);

    logic [SUM_W-1:0] span;
    logic [SUM_W-1:0] reach;
    logic             in_top;
    logic             in_fixed;

    // Fixed low region test: a bit-slice when the size is a power of two.
    generate
        if (FIX_POW2) begin : g_fix_slice
            assign in_fixed = (addr[ADDR_W-1:FIX_LOG2] == '0);
        end else begin : g_fix_cmp
            assign in_fixed = (addr < ADDR_W'(FIXED_WORDS));
        end
    endgenerate

    // Top region test: address plus span reaches past the end of the space.
    always_comb begin
        span   = SUM_W'(cfg.top_blocks) << BLK_LOG2;
        reach  = SUM_W'(addr) + span;
        in_top = (cfg.top_blocks != '0) && (reach >= (SUM_W'(1) << ADDR_W));
    end

    // Combine region membership with the armed state.
    always_comb begin
        rd_block = cfg.armed && in_top;
        wr_block = cfg.armed && (in_top || in_fixed);
    end
endmodule

// File: rtl/eep_guard_seq.sv
// Accepts host beats, tracks burst addressing, forwards or suppresses them.
// Assumes one host request at a time and a single mem_ack per mem_req.
module eep_guard_seq
    import eep_guard_pkg::*;
#(
    parameter int          ADDR_W    = 10,
    parameter int          DATA_W    = 16,
    parameter logic [15:0] HIDE_FILL = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_cont,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] beat_addr,
    input  logic              wr_block,
    input  logic              rd_block,
    output logic              sup_pulse,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    seq_state_e        state;
    logic [ADDR_W-1:0] next_addr;
    logic              drop_burst;
    logic              accept;
    logic              blk;

    // Resolve beat address and the block decision for this request.
    always_comb begin
        beat_addr = host_cont ? next_addr : host_addr;
        accept    = host_req && (state == SQ_IDLE) && !host_ack;
        blk       = host_we ? (wr_block || (host_cont && drop_burst)) : rd_block;
        sup_pulse = accept && blk;
    end

    // Handshake sequencer toward host and EEPROM side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            host_ack   <= 1'b0;
            host_rdata <= '0;
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
            next_addr  <= '0;
            drop_burst <= 1'b0;
        end else begin
            host_ack <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (accept) begin
                        next_addr  <= beat_addr + ADDR_W'(1);
                        drop_burst <= host_we && blk;
                        if (blk) begin
                            host_ack <= 1'b1;
                            if (!host_we) host_rdata <= DATA_W'(HIDE_FILL);
                        end else begin
                            mem_req   <= 1'b1;
                            mem_we    <= host_we;
                            mem_addr  <= beat_addr;
                            mem_wdata <= host_wdata;
                            state     <= SQ_WAIT;
                        end
                    end
                end
                SQ_WAIT: begin
                    if (mem_ack) begin
                        mem_req  <= 1'b0;
                        host_ack <= 1'b1;
                        if (!mem_we) host_rdata <= mem_rdata;
                        state    <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack); // R7
    AST_BLOCK_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && blk) |=> (host_ack && !mem_req)); // R7
    AST_FWD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !blk) |=> (mem_req && !host_ack)); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R6
    AST_ACK_AFTER_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (host_ack && !mem_req)); // R6
endmodule

// File: rtl/eep_guard.sv
// Top of the EEPROM access guard: configuration capture, address check,
// beat sequencer and the sticky suppression flag.
// Assumes synchronous active-low reset and pulse-style handshakes.
module eep_guard
    import eep_guard_pkg::*;
#(
    parameter int          ADDR_W      = 10,
    parameter int          DATA_W      = 16,
    parameter int          BLK_LOG2    = 6,
    parameter int          FIXED_WORDS = 16,
    parameter logic [15:0] HIDE_FILL   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_word,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_cont,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              blocked_clr,
    output logic              blocked_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    prot_cfg_t         cfg;
    logic              loaded;
    logic [ADDR_W-1:0] beat_addr;
    logic              wr_block;
    logic              rd_block;
    logic              sup_pulse;

    eep_guard_arm #(.DATA_W(DATA_W)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .load_word  (load_word),
        .cfg        (cfg),
        .loaded     (loaded)
    );

    eep_guard_check #(
        .ADDR_W      (ADDR_W),
        .BLK_LOG2    (BLK_LOG2),
        .FIXED_WORDS (FIXED_WORDS)
    ) u_check (
        .cfg      (cfg),
        .addr     (beat_addr),
        .wr_block (wr_block),
        .rd_block (rd_block)
    );

    eep_guard_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .HIDE_FILL (HIDE_FILL)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_cont  (host_cont),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_ack   (host_ack),
        .host_rdata (host_rdata),
        .beat_addr  (beat_addr),
        .wr_block   (wr_block),
        .rd_block   (rd_block),
        .sup_pulse  (sup_pulse),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    // Sticky suppression flag; a new suppression wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           blocked_flag <= 1'b0;
        else if (sup_pulse)   blocked_flag <= 1'b1;
        else if (blocked_clr) blocked_flag <= 1'b0;
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        sup_pulse |=> blocked_flag); // R10
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked_flag && !blocked_clr) |=> blocked_flag); // R10
endmodule

// File: tb/tb_eep_guard.sv
// Scoreboard bench: the driver predicts each access and queues it, the
// monitor compares on every host_ack; an EEPROM model answers requests.
module tb_eep_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_valid = 1'b0;
    logic [DW-1:0] load_word = '0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic          host_cont = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_ack;
    logic [DW-1:0] host_rdata;
    logic          blocked_clr = 1'b0;
    logic          blocked_flag;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep_guard dut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
        .host_req(host_req), .host_we(host_we), .host_cont(host_cont),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .blocked_clr(blocked_clr), .blocked_flag(blocked_flag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;

    // EEPROM model: acknowledges two cycles after a request appears.
    int            mem_count = 0;
    logic [AW-1:0] seen_addr = '0;
    logic          seen_we = 1'b0;
    logic [DW-1:0] seen_wdata = '0;
    int            wait_cnt = 0;
    assign mem_rdata = DW'(mem_addr) ^ 16'hA5A5;

    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wait_cnt == 0) begin
                mem_count  <= mem_count + 1;
                seen_addr  <= mem_addr;
                seen_we    <= mem_we;
                seen_wdata <= mem_wdata;
            end
            if (wait_cnt == 1) begin
                mem_ack  <= 1'b1;
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    typedef struct {
        bit            is_rd;
        logic [DW-1:0] rd;
        int            cnt_exp;
        bit            fwd;
        logic [AW-1:0] addr;
        bit            we;
        logic [DW-1:0] wd;
        string         tag;
    } item_t;
    item_t sb[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per host acknowledge.
    int acks = 0;
    always @(negedge clk) begin
        if (host_ack) begin
            acks++;
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected host_ack", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(mem_count == it.cnt_exp, {it.tag, " mem access count"},
                      32'(mem_count), 32'(it.cnt_exp));
                if (it.is_rd)
                    check(host_rdata == it.rd, {it.tag, " read data"},
                          32'(host_rdata), 32'(it.rd));
                if (it.fwd) begin
                    check(seen_addr == it.addr && seen_we == it.we,
                          {it.tag, " forwarded address/dir"},
                          {21'd0, seen_we, seen_addr}, {21'd0, it.we, it.addr});
                    if (it.we)
                        check(seen_wdata == it.wd, {it.tag, " forwarded wdata"},
                              32'(seen_wdata), 32'(it.wd));
                end
            end
        end
    end

    // Bench-side protection model.
    bit            b_loaded = 0;
    bit            b_armed = 0;
    int            b_top = 0;
    logic [AW-1:0] b_next = '0;
    bit            b_drop = 0;
    int            exp_cnt = 0;

    function automatic bit in_top(input logic [AW-1:0] a);
        return (b_top != 0) && (int'(a) >= 1024 - b_top * 64);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(host_ack == 0 && mem_req == 0 && blocked_flag == 0,
              "R1 outputs during reset", {29'd0, host_ack, mem_req, blocked_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ack == 0 && mem_req == 0 && blocked_flag == 0,
              "R1 outputs after reset", {29'd0, host_ack, mem_req, blocked_flag}, 32'd0);
        b_loaded = 0; b_armed = 0; b_top = 0; b_next = '0; b_drop = 0;
    endtask

    task automatic do_load(input logic [DW-1:0] w);
        @(negedge clk);
        load_valid = 1'b1;
        load_word  = w;
        @(negedge clk);
        load_valid = 1'b0;
        if (!b_loaded) begin
            b_loaded = 1;
            b_armed  = (w[7:6] == 2'b01) && w[4];
            b_top    = int'(w[3:0]);
        end
    endtask

    task automatic acc(input bit we, input bit cont, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input string tag);
        item_t it;
        logic [AW-1:0] ad;
        bit blk;
        int n0;
        int guard;
        ad     = cont ? b_next : a;
        b_next = ad + 1'b1;
        if (we) blk = (b_armed && (ad < 16 || in_top(ad))) || (cont && b_drop);
        else    blk = b_armed && in_top(ad);
        b_drop = we && blk;
        if (!blk) exp_cnt++;
        it.is_rd = !we;
        it.rd = blk ? 16'hFFFF : (DW'(ad) ^ 16'hA5A5);
        it.cnt_exp = exp_cnt;
        it.fwd = !blk;
        it.addr = ad;
        it.we = we;
        it.wd = wd;
        it.tag = tag;
        sb.push_back(it);
        n0 = acks;
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_cont = cont; host_addr = a; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        if (blk)
            check(host_ack == 1'b1 && mem_req == 1'b0, {tag, " R7 one-cycle blocked ack"},
                  {30'd0, host_ack, mem_req}, 32'd2);
        else
            check(mem_req == 1'b1 && host_ack == 1'b0, {tag, " R6 request raised"},
                  {30'd0, host_ack, mem_req}, 32'd1);
        guard = 0;
        while (acks == n0 && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        if (acks == n0) check(1'b0, {tag, " R6 no host_ack"}, 32'd0, 32'd1);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset();
        // R3: accesses before word 0 is loaded pass through
        acc(1, 0, 10'd0, 16'h1111, "R3 write w0 unloaded");
        acc(0, 0, 10'd1000, 16'h0, "R3 read top unloaded");
        // armed: signature 01, enable, two top blocks -> base 896
        do_load(16'h0052);
        acc(1, 0, 10'd5, 16'h2222, "R4 write fixed region");
        check(blocked_flag == 1'b1, "R10 flag set", 32'(blocked_flag), 32'd1);
        acc(0, 0, 10'd5, 16'h0, "R4 read fixed region");
        acc(1, 0, 10'd16, 16'h3333, "R4 write word 16");
        acc(0, 0, 10'd900, 16'h0, "R5 read hidden");
        acc(1, 0, 10'd1000, 16'h4444, "R5 write hidden");
        acc(0, 0, 10'd895, 16'h0, "R5 read below top");
        @(negedge clk);
        blocked_clr = 1'b1;
        @(negedge clk);
        blocked_clr = 1'b0;
        check(blocked_flag == 1'b0, "R10 flag cleared", 32'(blocked_flag), 32'd0);
        acc(0, 0, 10'd200, 16'h0, "R10 legal read keeps flag");
        check(blocked_flag == 1'b0, "R10 flag stays clear", 32'(blocked_flag), 32'd0);
        // R11: a second load must not disarm
        do_load(16'h0000);
        acc(1, 0, 10'd3, 16'h5555, "R11 second load ignored");
        acc(0, 0, 10'd1023, 16'h0, "R11 top still hidden");
        // R8: read burst crossing into the hidden region
        acc(0, 0, 10'd894, 16'h0, "R8 burst beat0");
        acc(0, 1, 10'd0, 16'h0, "R8 burst beat1");
        acc(0, 1, 10'd0, 16'h0, "R8 burst beat2 hidden");
        acc(0, 1, 10'd0, 16'h0, "R8 burst beat3 hidden");
        // R9: write burst dropped after the first suppressed beat
        acc(1, 0, 10'd14, 16'hA001, "R9 wburst beat0");
        acc(1, 1, 10'd0, 16'hA002, "R9 wburst beat1");
        acc(1, 1, 10'd0, 16'hA003, "R9 wburst beat2 dropped");
        acc(1, 0, 10'd17, 16'hA004, "R9 new start passes");
        acc(1, 1, 10'd0, 16'hA005, "R9 continuation passes");
        // R2: wrong signature leaves protection off
        do_reset();
        do_load(16'h0092);
        acc(1, 0, 10'd0, 16'hB001, "R2 bad signature");
        acc(0, 0, 10'd1020, 16'h0, "R2 bad signature top read");
        // R2: enable bit clear leaves protection off
        do_reset();
        do_load(16'h0042);
        acc(1, 0, 10'd2, 16'hB002, "R2 enable clear");
        // R5: size zero hides nothing but low words stay write-protected
        do_reset();
        do_load(16'h0050);
        acc(0, 0, 10'd1023, 16'h0, "R5 size zero read top");
        acc(1, 0, 10'd1023, 16'hB003, "R5 size zero write top");
        acc(1, 0, 10'd15, 16'hB004, "R4 write word 15");
        // R5: maximum size field
        do_reset();
        do_load(16'h005F);
        acc(0, 0, 10'd64, 16'h0, "R5 max size hidden low edge");
        acc(0, 0, 10'd63, 16'h0, "R5 max size just below");
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R7 scoreboard drained", 32'(sb.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule